// File: doc/BRIEF.md
# Two-Wire Link Escape Detector

This block watches a two-wire debug link made of a link clock line and a bidirectional mode/data line. Ordinary traffic moves at most one data value per link-clock period. An escape is out-of-band control: the host holds the link clock high and toggles the data line several times. The number of data-line edges inside one clock-high phase selects the kind of escape.

Both link lines enter through synchronizer chains clocked by a fast system clock. Data-line edges are counted while the synchronized link clock stays high. The count restarts on every new high phase. When the link clock falls, the count is classified. A count of two or more produces a one-cycle strobe carrying the escape kind. A reset escape also raises a separate one-cycle reset pulse. The host's link toggle rate must be at most a quarter of the system clock rate.

Top module: `esc_detect`

## Requirements
- R1: While `rst_ni` is low, and in the first cycles after it is released with both link lines low, `esc_valid_o`, `esc_kind_o` and `esc_reset_o` are all 0.
- R2: Data-line toggles while the link clock is low are not counted. A later high phase with no toggles produces no strobe, whatever happened in the low phase.
- R3: A high phase containing 0 or 1 data-line edges produces no strobe.
- R4: 2 or 3 edges in one high phase produce a strobe with `esc_kind_o` = 0 (custom).
- R5: 4 or 5 edges produce a strobe with `esc_kind_o` = 1 (deselection).
- R6: 6 or 7 edges produce a strobe with `esc_kind_o` = 2 (selection).
- R7: 8 or more edges produce a strobe with `esc_kind_o` = 3 (reset). This holds for 10 edges, and for bursts far beyond the counter's range, because the counter saturates at its maximum instead of wrapping.
- R8: `esc_valid_o` is high for exactly one cycle per classified fall. `esc_reset_o` is high exactly when a kind-3 strobe is issued. `esc_kind_o` reads 0 whenever `esc_valid_o` is low.
- R9: The edge count restarts at each rising link clock. Two back-to-back high phases of 3 edges each produce two custom strobes and never a deselection strobe.
- R10: With 2 synchronizer stages, the strobe appears at the third system clock edge that samples the link clock low after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling system clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lnk_clk_i | input | 1 | Link clock line, asynchronous |
| lnk_dat_i | input | 1 | Link mode/data line, asynchronous |
| esc_valid_o | output | 1 | One-cycle strobe, an escape was classified |
| esc_kind_o | output | 2 | 0 custom, 1 deselection, 2 selection, 3 reset; 0 when no strobe |
| esc_reset_o | output | 1 | One-cycle pulse on a reset escape |

## Verification
The assertions check four properties on every cycle:
- the strobe is a single-cycle pulse;
- the reset pulse only occurs with a strobe;
- the count stays frozen while the link clock is low;
- every issued kind agrees with the count range that produced it.

Only the bench's scenarios can show two further properties. The first is that each edge count from 0 through 10, plus a long saturating burst, maps to the right kind. The second is that low-phase toggles and consecutive high phases leave no residue in the next classification. A cycle-accurate reference model in the bench also pins the strobe to its exact cycle.

// File: rtl/esc_detect.sv
module esc_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lnk_clk_i,
  input  logic       lnk_dat_i,
  output logic       esc_valid_o,
  output logic [1:0] esc_kind_o,
  output logic       esc_reset_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int               MSB     = SYNC_STAGES - 1;

  logic [MSB:0]       clk_sh, dat_sh;
  logic               lk_s, dk_s, lk_q, dk_q;
  logic               rise, fall, tog, hit;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         kind_c;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          clk_sh <= '0;
          dat_sh <= '0;
        end else begin
          clk_sh <= lnk_clk_i;
          dat_sh <= lnk_dat_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          clk_sh <= '0;
          dat_sh <= '0;
        end else begin
          clk_sh <= {clk_sh[MSB-1:0], lnk_clk_i};
          dat_sh <= {dat_sh[MSB-1:0], lnk_dat_i};
        end
      end
    end
  endgenerate

  assign lk_s = clk_sh[MSB];
  assign dk_s = dat_sh[MSB];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lk_q <= 1'b0;
      dk_q <= 1'b0;
    end else begin
      lk_q <= lk_s;
      dk_q <= dk_s;
    end
  end

  assign rise = lk_s & ~lk_q;
  assign fall = ~lk_s & lk_q;
  assign tog  = lk_s & lk_q & (dk_s ^ dk_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                     cnt <= '0;
    else if (rise)                   cnt <= '0;
    else if (tog && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (int'(cnt) >= 8)      kind_c = 2'd3;
    else if (int'(cnt) >= 6) kind_c = 2'd2;
    else if (int'(cnt) >= 4) kind_c = 2'd1;
    else                     kind_c = 2'd0;
  end

  assign hit = fall && (int'(cnt) >= 2);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      esc_valid_o <= 1'b0;
      esc_kind_o  <= 2'd0;
      esc_reset_o <= 1'b0;
    end else begin
      esc_valid_o <= hit;
      esc_kind_o  <= hit ? kind_c : 2'd0;
      esc_reset_o <= hit && (kind_c == 2'd3);
    end
  end

endmodule

// File: rtl/esc_detect_chk.sv
module esc_detect_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_s,
  input logic             lk_q,
  input logic [CNT_W-1:0] cnt,
  input logic             esc_valid_o,
  input logic [1:0]       esc_kind_o,
  input logic             esc_reset_o
);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_valid_o |=> !esc_valid_o);

  a_r8_reset_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_reset_o |-> (esc_valid_o && esc_kind_o == 2'd3));

  a_r8_idle_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !esc_valid_o |-> esc_kind_o == 2'd0);

  a_r2_low_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lk_s && !lk_q) |=> $stable(cnt));

  a_r3_min_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_valid_o |-> int'(cnt) >= 2);

  a_r4_custom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_valid_o && esc_kind_o == 2'd0) |-> (int'(cnt) == 2 || int'(cnt) == 3));

  a_r5_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_valid_o && esc_kind_o == 2'd1) |-> (int'(cnt) == 4 || int'(cnt) == 5));

  a_r6_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_valid_o && esc_kind_o == 2'd2) |-> (int'(cnt) == 6 || int'(cnt) == 7));

  a_r7_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_valid_o && esc_kind_o == 2'd3) |-> int'(cnt) >= 8);

endmodule

bind esc_detect esc_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_s(lk_s), .lk_q(lk_q), .cnt(cnt),
  .esc_valid_o(esc_valid_o), .esc_kind_o(esc_kind_o), .esc_reset_o(esc_reset_o)
);

// File: tb/esc_detect_bench.sv
`timescale 1ns/1ps
module esc_detect_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lclk = 1'b0;
  logic ldat = 1'b0;
  logic       v;
  logic [1:0] k;
  logic       r;

  always #4 clk = ~clk;

  esc_detect u_esc_detect (
    .clk_i(clk), .rst_ni(rst_n), .lnk_clk_i(lclk), .lnk_dat_i(ldat),
    .esc_valid_o(v), .esc_kind_o(k), .esc_reset_o(r)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: queue of raw samples, integer count
  logic [1:0] hist[$];
  int m_cnt = 0;
  int e_v = 0, e_k = 0, e_r = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{2'b00, 2'b00, 2'b00};
      m_cnt = 0; e_v = 0; e_k = 0; e_r = 0;
    end else begin
      logic [1:0] a, b;
      int kk;
      a = hist[1]; b = hist[2];
      kk = (m_cnt >= 8) ? 3 : (m_cnt >= 6) ? 2 : (m_cnt >= 4) ? 1 : 0;
      if (b[1] && !a[1] && m_cnt >= 2) begin
        e_v = 1; e_k = kk; e_r = (kk == 3) ? 1 : 0;
      end else begin
        e_v = 0; e_k = 0; e_r = 0;
      end
      if (a[1] && !b[1]) m_cnt = 0;
      else if (a[1] && b[1] && a[0] != b[0] && m_cnt < 15) m_cnt++;
      hist.push_front({lclk, ldat});
      void'(hist.pop_back());
    end
  end

  // per-cycle comparison, away from the active edge (R10 timing, R8 shape, R1 after reset)
  int seen_n = 0;
  int seen_k = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 valid", int'(v), e_v);
      chk("R8 kind", int'(k), e_k);
      chk("R8 reset pulse", int'(r), e_r);
      if (v) begin seen_n++; seen_k = int'(k); end
    end
  end

  task automatic phase(input int n);
    @(negedge clk); lclk = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ldat = ~ldat;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    lclk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic scen(input string req, input int n, input int exp_n, input int exp_k);
    seen_n = 0; seen_k = -1;
    phase(n);
    chk(req, seen_n, exp_n);
    if (exp_n > 0) chk(req, seen_k, exp_k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", int'(v), 0);
    chk("R1 kind in reset", int'(k), 0);
    chk("R1 reset in reset", int'(r), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", int'(v), 0);
    scen("R3 zero edges", 0, 0, 0);
    scen("R3 one edge", 1, 0, 0);
    scen("R4 two edges", 2, 1, 0);
    scen("R4 three edges", 3, 1, 0);
    scen("R5 four edges", 4, 1, 1);
    scen("R5 five edges", 5, 1, 1);
    scen("R6 six edges", 6, 1, 2);
    scen("R6 seven edges", 7, 1, 2);
    scen("R7 eight edges", 8, 1, 3);
    scen("R7 ten edges", 10, 1, 3);
    scen("R7 saturating burst", 40, 1, 3);
    // R2: toggles in the low phase, then a quiet high phase
    seen_n = 0;
    for (int i = 0; i < 9; i++) begin ldat = ~ldat; repeat (2) @(negedge clk); end
    repeat (4) @(negedge clk);
    chk("R2 no strobe from low toggles", seen_n, 0);
    scen("R2 quiet high after low toggles", 0, 0, 0);
    // R9: two back-to-back 3-edge phases
    seen_n = 0;
    phase(3);
    chk("R9 first phase custom", seen_k, 0);
    phase(3);
    chk("R9 two custom strobes", seen_n, 2);
    chk("R9 second phase custom", seen_k, 0);
    // R7 then mid-run reset, R1
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid held in reset", int'(v), 0);
    rst_n = 1'b1;
    scen("R6 after reset", 6, 1, 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule